// File: doc/BRIEF.md
# Display Host Register Interface

This block sits between a host bus and the core of an eight-digit alphanumeric display. The host drives active-low chip-enable, write and read strobes, a space-select line, a five-bit address and an eight-bit data byte. All of these are sampled on the system clock. Two storage spaces share the bus. The first is a bank of per-digit flash attribute bits, reached with the space-select low. The second is a single eight-bit control word, reached with the space-select high and the address pattern `10xxx`.

The control word holds three brightness bits, a flash enable, a blink enable, a self-test result, a self-test start/busy bit and a clear bit. Writing the clear bit wipes the flash bits and sends a one-cycle clear to the character storage, and the bit then drops by itself. Writing the start bit runs a fixed-length self test. In this model the test always passes and reports through the result bit.

Reads return data one cycle after the read strobe is sampled, together with a valid flag. Host strobes cannot be stalled, so the read data path has no back-pressure. Each read that is sampled yields exactly one valid beat on the next cycle, and the host must capture it then.

Top module: `dsp_host_if`

## Requirements
- R1: A write commits only on the first clock edge at which `ce_n`=0, `wr_n`=0 and `rd_n`=1. Holding that condition for more cycles commits nothing further. With `wr_n` and `rd_n` both low, nothing is written.
- R2: A write with `ctl_sel`=0 stores `wdata[0]` into digit `addr[2:0]`, where code 0 is the leftmost digit and maps to `flash_bits[0]`. The bits `wdata[7:1]` and `addr[4:3]` have no effect, and no other digit changes.
- R3: A write with `ctl_sel`=1, `addr[4]`=1 and `addr[3]`=0 updates the control word at once: bits 2..0 are brightness, bit 3 is flash enable, bit 4 is blink enable and bit 7 is clear. `addr[2:0]` is ignored. Writes to any other address with `ctl_sel`=1 change nothing.
- R4: A control write with bit 6 = 0 leaves bit 5 (the test result) unchanged, whatever is written there.
- R5: A control write with bit 7 = 1 shows bit 7 and `clr_pulse` high for exactly one cycle. On the next edge all flash bits become 0 and bit 7 returns to 0.
- R6: A control write with bit 6 = 1 sets bit 6 and `test_busy` and clears bit 5. After exactly `TEST_CYCLES` cycles of busy, bit 6 falls and bit 5 reads 1 (pass).
- R7: While a self test is busy, control writes update bits 7 and 4..0 but leave bits 6 and 5 unchanged.
- R8: A read with `ce_n`=0, `rd_n`=0 and `wr_n`=1 returns data on `rdata` with `rdata_vld`=1 one cycle later. In the flash space the digit bit appears in bit 0 and bits 7..1 are zero. In the control space the full control word is returned.
- R9: `rdata` is zero whenever `rdata_vld` is low. It is also zero for a read of an unmapped address. A cycle with both strobes low produces no valid beat.
- R10: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| ctl_sel | input | 1 | 0 selects the flash bits, 1 selects the control space |
| addr | input | 5 | Bus address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid one cycle after a read |
| rdata_vld | output | 1 | Read data valid |
| ctrl_word | output | 8 | Registered control word |
| flash_bits | output | 8 | Per-digit flash attribute bits, index 0 leftmost |
| clr_pulse | output | 1 | One-cycle clear for the character storage |
| test_busy | output | 1 | Self test in progress |

## Verification
The hardest situation to reach from the ports is a control write that lands while a self test is running. The test's own bits must then stay locked while the other fields take the new value. The stimulus starts a test and issues a write carrying a contradicting bit 5 and bit 6 a few cycles later, well inside the busy window. A randomized phase then keeps re-triggering tests, clears and strobe conflicts, so that writes also land on the test's final cycle. A cycle-accurate model compares every output on every clock.

// File: rtl/dsp_if_pkg.sv
package dsp_if_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 5;

  localparam int BIT_CLR = 7;
  localparam int BIT_TST = 6;
  localparam int BIT_RES = 5;
  localparam int BIT_BLK = 4;
  localparam int BIT_FLE = 3;
  localparam int BRT_W   = 3;

  typedef enum logic [1:0] {
    SPACE_NONE  = 2'd0,
    SPACE_FLASH = 2'd1,
    SPACE_CTRL  = 2'd2
  } space_e;

  function automatic space_e decode_space(input logic sel, input logic [ADDR_W-1:0] a);
    if (!sel)
      return SPACE_FLASH;
    else if (a[4] && !a[3])
      return SPACE_CTRL;
    else
      return SPACE_NONE;
  endfunction
endpackage

// File: rtl/dsp_bus_decode.sv
module dsp_bus_decode
  import dsp_if_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              ctl_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_fire,
  output logic              rd_act,
  output space_e            space,
  output logic [IDX_W-1:0]  idx
);
  logic wr_lvl;
  logic wr_seen_q;

  // a strobe pair with both lines low is undefined and qualifies neither way
  assign wr_lvl  = !ce_n && !wr_n && rd_n;
  assign rd_act  = !ce_n && !rd_n && wr_n;
  assign wr_fire = wr_lvl && !wr_seen_q;
  assign space   = decode_space(ctl_sel, addr);
  assign idx     = addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_seen_q <= 1'b0;
    else        wr_seen_q <= wr_lvl;
  end

  AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire); // R1
endmodule

// File: rtl/dsp_flash_bank.sv
module dsp_flash_bank #(
  parameter int N_DIGITS = 8,
  localparam int IDX_W   = $clog2(N_DIGITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [IDX_W-1:0]    idx,
  input  logic                bit_in,
  input  logic                clr,
  output logic [N_DIGITS-1:0] flash
);
  for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flash[g] <= 1'b0;
      else if (clr)
        flash[g] <= 1'b0;
      else if (we && (idx == IDX_W'(g)))
        flash[g] <= bit_in;
    end
  end

  AST_CLR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flash == '0)); // R5
  AST_ONE_DIGIT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> ($countones(flash ^ $past(flash)) <= 1)); // R2
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr) |=> $stable(flash)); // R2
endmodule

// File: rtl/dsp_ctrl_reg.sv
module dsp_ctrl_reg
  import dsp_if_pkg::*;
#(
  parameter int TEST_CYCLES = 16,
  localparam int CNT_W      = $clog2(TEST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              busy,
  output logic              clr
);
  logic [BRT_W-1:0] brt_q;
  logic             fle_q;
  logic             blk_q;
  logic             res_q;
  logic             busy_q;
  logic             clr_q;
  logic [CNT_W-1:0] cnt_q;

  // plain fields: every accepted write replaces them
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brt_q <= '0;
      fle_q <= 1'b0;
      blk_q <= 1'b0;
    end else if (we) begin
      brt_q <= wdata[BRT_W-1:0];
      fle_q <= wdata[BIT_FLE];
      blk_q <= wdata[BIT_BLK];
    end
  end

  // clear bit lives for exactly one cycle unless rewritten
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_q <= 1'b0;
    else        clr_q <= we && wdata[BIT_CLR];
  end

  // self-test engine; locks bits 6 and 5 while running
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      res_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        res_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (we && wdata[BIT_TST]) begin
      busy_q <= 1'b1;
      res_q  <= 1'b0;
      cnt_q  <= CNT_W'(TEST_CYCLES - 1);
    end
  end

  assign ctrl_word = {clr_q, busy_q, res_q, blk_q, fle_q, brt_q};
  assign busy      = busy_q;
  assign clr       = clr_q;

  AST_CLR_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q); // R5
  AST_PASS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> res_q); // R6
  AST_RES_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !res_q); // R6
  AST_RES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[BIT_TST] && !busy_q) |=> (res_q == $past(res_q))); // R4
  AST_TEST_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy_q && (cnt_q != '0)) |=> (busy_q && !res_q)); // R7
endmodule

// File: rtl/dsp_read_port.sv
module dsp_read_port
  import dsp_if_pkg::*;
#(
  parameter int N_DIGITS = 8,
  localparam int IDX_W   = $clog2(N_DIGITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_act,
  input  space_e              space,
  input  logic [IDX_W-1:0]    idx,
  input  logic [N_DIGITS-1:0] flash,
  input  logic [DATA_W-1:0]   ctrl_word,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdata_vld
);
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    unique case (space)
      SPACE_FLASH: sel_d = {{(DATA_W-1){1'b0}}, flash[idx]};
      SPACE_CTRL:  sel_d = ctrl_word;
      default:     sel_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata     <= rd_act ? sel_d : '0;
      rdata_vld <= rd_act;
    end
  end

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_vld |-> (rdata == '0)); // R9
  AST_FLASH_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && space == SPACE_FLASH) |=> (rdata[DATA_W-1:1] == '0)); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && space == SPACE_NONE) |=> (rdata_vld && rdata == '0)); // R9
endmodule

// File: rtl/dsp_host_if.sv
module dsp_host_if
  import dsp_if_pkg::*;
#(
  parameter int N_DIGITS    = 8,
  parameter int TEST_CYCLES = 16,
  localparam int IDX_W      = $clog2(N_DIGITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                wr_n,
  input  logic                rd_n,
  input  logic                ctl_sel,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                rdata_vld,
  output logic [DATA_W-1:0]   ctrl_word,
  output logic [N_DIGITS-1:0] flash_bits,
  output logic                clr_pulse,
  output logic                test_busy
);
  logic             wr_fire;
  logic             rd_act;
  space_e           space;
  logic [IDX_W-1:0] idx;
  logic             flash_we;
  logic             ctrl_we;

  dsp_bus_decode #(.IDX_W(IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
    .ctl_sel(ctl_sel), .addr(addr),
    .wr_fire(wr_fire), .rd_act(rd_act), .space(space), .idx(idx)
  );

  assign flash_we = wr_fire && (space == SPACE_FLASH);
  assign ctrl_we  = wr_fire && (space == SPACE_CTRL);

  dsp_ctrl_reg #(.TEST_CYCLES(TEST_CYCLES)) u_ctl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(wdata),
    .ctrl_word(ctrl_word), .busy(test_busy), .clr(clr_pulse)
  );

  dsp_flash_bank #(.N_DIGITS(N_DIGITS)) u_fl (
    .clk(clk), .rst_n(rst_n), .we(flash_we), .idx(idx),
    .bit_in(wdata[0]), .clr(clr_pulse), .flash(flash_bits)
  );

  dsp_read_port #(.N_DIGITS(N_DIGITS)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .space(space), .idx(idx),
    .flash(flash_bits), .ctrl_word(ctrl_word),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );

  AST_CONFLICT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !wr_n && !rd_n) |=> !rdata_vld); // R9
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && space == SPACE_NONE && !clr_pulse && !test_busy) |=> $stable(ctrl_word)); // R3
endmodule

// File: tb/sim_dsp_host_if.sv
`timescale 1ns/1ps
module sim_dsp_host_if;
  localparam int TC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ctl_sel = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, ctrl_word, flash_bits;
  logic       rdata_vld, clr_pulse, test_busy;

  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  dsp_host_if #(.N_DIGITS(8), .TEST_CYCLES(TC)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .wr_n(wr_n), .rd_n(rd_n),
    .ctl_sel(ctl_sel), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_vld(rdata_vld), .ctrl_word(ctrl_word),
    .flash_bits(flash_bits), .clr_pulse(clr_pulse), .test_busy(test_busy)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_flash, m_rdata;
  logic [4:0] m_lo;
  logic       m_clr, m_busy, m_res, m_vld, m_prev;
  int         m_cnt;

  function automatic logic [7:0] m_word();
    return {m_clr, m_busy, m_res, m_lo};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flash = 0; m_rdata = 0; m_lo = 0; m_clr = 0; m_busy = 0;
      m_res = 0; m_vld = 0; m_prev = 0; m_cnt = 0;
    end else begin
      logic wl, rl, fire, hit, ob, nclr;
      wl   = !ce_n && !wr_n && rd_n;
      rl   = !ce_n && !rd_n && wr_n;
      fire = wl && !m_prev;
      m_prev = wl;
      hit  = ctl_sel && addr[4] && !addr[3];
      ob   = m_busy;
      if (rl) m_rdata = !ctl_sel ? {7'd0, m_flash[addr[2:0]]} : (hit ? m_word() : 8'd0);
      else    m_rdata = 0;
      m_vld = rl;
      if (m_clr) m_flash = 0;
      else if (fire && !ctl_sel) m_flash[addr[2:0]] = wdata[0];
      nclr = 1'b0;
      if (ob) begin
        if (m_cnt == 0) begin m_busy = 0; m_res = 1; end
        else m_cnt--;
      end
      if (fire && hit) begin
        m_lo = wdata[4:0];
        nclr = wdata[7];
        if (!ob && wdata[6]) begin m_busy = 1; m_res = 0; m_cnt = TC - 1; end
      end
      m_clr = nclr;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(flash_bits, m_flash, "R2 flash bits vs model");
      chk(ctrl_word, m_word(), "R3 control word vs model");
      chk({7'd0, clr_pulse}, {7'd0, m_clr}, "R5 clear pulse vs model");
      chk({7'd0, test_busy}, {7'd0, m_busy}, "R6 busy vs model");
      chk(rdata, m_rdata, "R8 read data vs model");
      chk({7'd0, rdata_vld}, {7'd0, m_vld}, "R9 read valid vs model");
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    ce_n = 1; wr_n = 1; rd_n = 1;
  endtask

  task automatic bus_wr(input logic sel, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; wr_n = 0; rd_n = 1; ctl_sel = sel; addr = a; wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic bus_rd(input logic sel, input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    ce_n = 0; rd_n = 0; wr_n = 1; ctl_sel = sel; addr = a;
    @(negedge clk);
    idle();
    d = rdata;
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    chk(ctrl_word, 8'h00, "R10 reset control word");
    chk(flash_bits, 8'h00, "R10 reset flash");
    chk({rdata_vld, clr_pulse, test_busy, 5'd0}, 8'h00, "R10 reset strobes");
    chk(rdata, 8'h00, "R10 reset rdata");
    rst_n = 1;
    @(negedge clk);

    bus_wr(0, 5'b00000, 8'hFF);
    chk(flash_bits, 8'h01, "R2 leftmost digit set");
    bus_wr(0, 5'b11111, 8'h01);
    chk(flash_bits, 8'h81, "R2 rightmost, upper addr ignored");
    bus_wr(0, 5'b00000, 8'hFE);
    chk(flash_bits, 8'h80, "R2 upper data ignored, mark removed");
    bus_rd(0, 5'b00111, d);
    chk(d, 8'h01, "R8 flash read in bit 0");
    bus_rd(0, 5'b00001, d);
    chk(d, 8'h00, "R8 flash read clear digit");

    bus_wr(1, 5'b10101, 8'h1B);
    chk(ctrl_word, 8'h1B, "R3 control write, low addr ignored");
    bus_rd(1, 5'b10000, d);
    chk(d, 8'h1B, "R8 control read");
    bus_wr(1, 5'b01000, 8'h05);
    chk(ctrl_word, 8'h1B, "R3 unmapped control address ignored");
    bus_rd(1, 5'b00000, d);
    chk(d, 8'h00, "R9 unmapped read zero");
    bus_wr(1, 5'b10000, 8'h3A);
    chk(ctrl_word, 8'h1A, "R4 bit 5 ignored without start");

    // held strobe: only the first edge commits
    @(negedge clk);
    ce_n = 0; wr_n = 0; rd_n = 1; ctl_sel = 1; addr = 5'b10000; wdata = 8'h02;
    @(negedge clk);
    wdata = 8'h07;
    repeat (2) @(negedge clk);
    idle();
    chk(ctrl_word, 8'h02, "R1 held write commits once");

    // both strobes low
    @(negedge clk);
    ce_n = 0; wr_n = 0; rd_n = 0; ctl_sel = 1; addr = 5'b10000; wdata = 8'h11;
    @(negedge clk);
    idle();
    chk(ctrl_word, 8'h02, "R1 conflicting strobes ignored");
    chk({7'd0, rdata_vld}, 8'h00, "R9 conflicting strobes no read");

    // self test
    bus_wr(1, 5'b10000, 8'h42);
    chk(ctrl_word, 8'h42, "R6 test started, result cleared");
    n = 0;
    while (test_busy && n < 1000) begin n++; @(negedge clk); end
    chk(8'(n), 8'(TC), "R6 busy length");
    chk(ctrl_word, 8'h22, "R6 pass reported");

    bus_wr(1, 5'b10000, 8'h40);
    repeat (2) @(negedge clk);
    bus_wr(1, 5'b10000, 8'h21);
    chk(ctrl_word, 8'h41, "R7 test bits locked during busy");
    while (test_busy) @(negedge clk);
    chk(ctrl_word, 8'h21, "R7 other fields kept after test");

    // clear
    bus_wr(0, 5'b00011, 8'h01);
    bus_wr(1, 5'b10000, 8'h83);
    chk(ctrl_word, 8'hA3, "R5 clear bit visible");
    chk({7'd0, clr_pulse}, 8'h01, "R5 clear pulse high");
    @(negedge clk);
    chk({7'd0, clr_pulse}, 8'h00, "R5 clear pulse one cycle");
    chk(flash_bits, 8'h00, "R5 flash wiped");
    chk(ctrl_word, 8'h23, "R5 clear bit self-reset");

    // randomized phase against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ce_n    = ($urandom_range(0, 3) == 0);
      wr_n    = $urandom_range(0, 1);
      rd_n    = $urandom_range(0, 1);
      ctl_sel = $urandom_range(0, 1);
      addr    = ($urandom_range(0, 1) != 0) ? {2'b10, 3'($urandom_range(0, 7))}
                                            : 5'($urandom_range(0, 31));
      wdata   = 8'($urandom_range(0, 255));
    end
    idle();
    repeat (TC + 4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule